// File: doc/BRIEF.md
# Prescaled Up-Counting Timebase with Silent Software Update

This block is an up-counting timebase. A free-running prescaler divides the input clock by a programmable ratio. Each prescaler terminal count advances a main counter, which runs from zero up to a programmable period limit and then wraps to zero. Software programs the prescaler ratio, the period limit and a repetition count through a simple register write port. All three values land first in preload copies. They are copied into the working copies only on an update event, so a period that is already running is never disturbed.

An update event happens in two cases. The first is when the main counter wraps and the repetition down-counter has reached zero. The second is when software writes the control register with the update-generate bit set. A software update clears both counters, loads the working copies and always pulses the update-event output. A source-select bit in the same control write decides whether that software update also pulses the update-request output, which would drive an interrupt or DMA request, or whether it reloads the registers silently. A wrap-driven update always pulses the request. The enable bit freezes or resumes counting without losing the count.

The write port is a plain strobe, address and data. It has no back-pressure, and every write completes in the cycle it is presented.

Top module: `upd_timebase`

## Requirements
- R1: After reset the counter output is 0, both pulse outputs are low, counting is disabled, the working prescaler ratio is 0 and the working period limit is all ones.
- R2: While enabled, the counter output steps through 0, 1, ..., L and then returns to 0, where L is the working period limit.
- R3: The counter advances once every P+1 clock cycles, where P is the working prescaler ratio. With no repetition, the update request therefore recurs every (P+1)*(L+1) cycles.
- R4: Writes to the prescaler (address 1), period (address 2) and repetition (address 3) registers change only the preload copies. The working copies take the new values at the next update event.
- R5: Writing address 0 with bit 2 set (update-generate) clears the counter and the prescaler count on that clock edge, loads all working copies and pulses the update-event output for one cycle starting with that edge.
- R6: If that same control write has bit 1 set (counter-only source), the software update leaves the update-request output low.
- R7: If that same control write has bit 1 clear (any-event source), the software update pulses the update-request output together with the update event.
- R8: A counter wrap with the repetition down-counter at zero pulses both outputs for one cycle, whatever the source-select bit.
- R9: With repetition value N, an update event occurs once every N+1 counter wraps. The down-counter reloads from the repetition preload on every update event.
- R10: Bit 0 of address 0 is the enable. While it is clear, the counter and prescaler hold their values. Setting it again resumes counting from the held value.
- R11: The update-request output is never high without the update-event output, and both are single-cycle pulses registered one edge after their cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 prescaler, 2 period, 3 repetition |
| wr_data | input | DATA_W | Write data; control bits are 0 enable, 1 counter-only source, 2 update-generate |
| cnt_o | output | CNT_W | Current counter value |
| upd_evt_o | output | 1 | Update event pulse |
| upd_req_o | output | 1 | Update request pulse (interrupt or DMA request) |

## Verification
The bench builds the block with an 8-bit counter, an 8-bit prescaler and a 4-bit repetition counter. These widths make periods of a few dozen cycles, so a single run covers full wraps, a change of the period limit in the middle of a period and a three-period repetition window. A behavioural model of the timebase runs alongside the design and is compared with the counter and both pulses on every clock. Directed checks also measure the distances between request pulses and the hold behaviour while the enable is clear.

// File: rtl/utb_pkg.sv
package utb_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PSC  = 2'd1,
    REG_ARR  = 2'd2,
    REG_REP  = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SRC_BIT = 1;
  localparam int CTRL_UG_BIT  = 2;
endpackage

// File: rtl/utb_shadow.sv
module utb_shadow #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_val,
  input  logic         load,
  output logic [W-1:0] pre_q,
  output logic [W-1:0] act_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= RST_VAL;
      act_q <= RST_VAL;
    end else begin
      if (wr) pre_q <= wr_val;
      if (load) act_q <= pre_q;
    end
  end

  // R4: a preload write without an update leaves the working copy unchanged
  a_r4_preload_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !load) |=> $stable(act_q));
endmodule

// File: rtl/utb_regs.sv
module utb_regs
  import utb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              uev,
  output logic              en_q,
  output logic              sw_ug,
  output logic              src_cnt_only,
  output logic [PSC_W-1:0]  psc_act,
  output logic [CNT_W-1:0]  arr_act,
  output logic [REP_W-1:0]  rep_pre
);
  localparam logic [CNT_W-1:0] ARR_RST = '1;

  logic ctrl_wr, psc_wr, arr_wr, rep_wr;
  logic [PSC_W-1:0] psc_pre_unused;
  logic [CNT_W-1:0] arr_pre_unused;
  logic [REP_W-1:0] rep_act_unused;

  assign ctrl_wr      = wr_en && (wr_addr == REG_CTRL);
  assign psc_wr       = wr_en && (wr_addr == REG_PSC);
  assign arr_wr       = wr_en && (wr_addr == REG_ARR);
  assign rep_wr       = wr_en && (wr_addr == REG_REP);
  assign sw_ug        = ctrl_wr && wr_data[CTRL_UG_BIT];
  assign src_cnt_only = wr_data[CTRL_SRC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else if (ctrl_wr) en_q <= wr_data[CTRL_EN_BIT];
  end

  utb_shadow #(.W(PSC_W), .RST_VAL('0)) u_psc (
    .clk(clk), .rst_n(rst_n), .wr(psc_wr), .wr_val(wr_data[PSC_W-1:0]),
    .load(uev), .pre_q(psc_pre_unused), .act_q(psc_act));

  utb_shadow #(.W(CNT_W), .RST_VAL(ARR_RST)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr(arr_wr), .wr_val(wr_data[CNT_W-1:0]),
    .load(uev), .pre_q(arr_pre_unused), .act_q(arr_act));

  // repetition: only the preload is consumed; the down-counter is its working copy
  utb_shadow #(.W(REP_W), .RST_VAL('0)) u_rep (
    .clk(clk), .rst_n(rst_n), .wr(rep_wr), .wr_val(wr_data[REP_W-1:0]),
    .load(1'b0), .pre_q(rep_pre), .act_q(rep_act_unused));

  // R1: counting disabled right after reset until a control write
  a_r1_en_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> (en_q == $past(en_q)));
endmodule

// File: rtl/utb_prescaler.sv
module utb_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sw_ug,
  input  logic [PSC_W-1:0] psc_act,
  output logic             tick
);
  localparam logic [PSC_W-1:0] ONE = PSC_W'(1);
  logic [PSC_W-1:0] pc_q;

  assign tick = en && !sw_ug && (pc_q == psc_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else if (sw_ug) pc_q <= '0;
    else if (en) pc_q <= (pc_q == psc_act) ? '0 : pc_q + ONE;
  end

  // R3: the prescaler count never passes the working ratio
  a_r3_pc_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= psc_act);
endmodule

// File: rtl/utb_counter.sv
module utb_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             sw_ug,
  input  logic [CNT_W-1:0] arr_act,
  output logic             ovf,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign ovf = tick && (cnt_q == arr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (sw_ug) cnt_q <= '0;
    else if (tick) cnt_q <= (cnt_q == arr_act) ? '0 : cnt_q + ONE;
  end

  // R2: the counter stays within 0..limit
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= arr_act);
  // R10: disabled and no software update means the count holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sw_ug) |=> $stable(cnt_q));
endmodule

// File: rtl/utb_repeat.sv
module utb_repeat #(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf,
  input  logic             sw_ug,
  input  logic             src_cnt_only,
  input  logic [REP_W-1:0] rep_pre,
  output logic             uev,
  output logic             req_fire
);
  localparam logic [REP_W-1:0] ONE = REP_W'(1);
  logic [REP_W-1:0] rep_q;
  logic wrap_upd;

  assign wrap_upd = ovf && (rep_q == '0);
  assign uev      = sw_ug || wrap_upd;
  assign req_fire = wrap_upd || (sw_ug && !src_cnt_only);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_q <= '0;
    else if (uev) rep_q <= rep_pre;
    else if (ovf) rep_q <= rep_q - ONE;
  end

  // R9: a wrap with repetitions left only decrements the down-counter
  a_r9_rep_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !sw_ug && rep_q != '0) |=> (rep_q == $past(rep_q) - ONE));
endmodule

// File: rtl/upd_timebase.sv
module upd_timebase
  import utb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_evt_o,
  output logic              upd_req_o
);
  logic en, sw_ug, src_cnt_only, tick, ovf, uev, req_fire;
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] arr_act;
  logic [REP_W-1:0] rep_pre;

  utb_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W), .REP_W(REP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .uev(uev), .en_q(en), .sw_ug(sw_ug), .src_cnt_only(src_cnt_only),
    .psc_act(psc_act), .arr_act(arr_act), .rep_pre(rep_pre));

  utb_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(en), .sw_ug(sw_ug), .psc_act(psc_act), .tick(tick));

  utb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .sw_ug(sw_ug),
    .arr_act(arr_act), .ovf(ovf), .cnt_q(cnt_o));

  utb_repeat #(.REP_W(REP_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .sw_ug(sw_ug), .src_cnt_only(src_cnt_only),
    .rep_pre(rep_pre), .uev(uev), .req_fire(req_fire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_evt_o <= 1'b0;
      upd_req_o <= 1'b0;
    end else begin
      upd_evt_o <= uev;
      upd_req_o <= req_fire;
    end
  end

  // R11: a request never appears without an event
  a_r11_req_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req_o |-> upd_evt_o);
  // R5: software update clears the counter and flags an event
  a_r5_ug_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ug |=> (cnt_o == '0 && upd_evt_o));
  // R6: counter-only source keeps a software update silent
  a_r6_silent_ug: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ug && src_cnt_only) |=> !upd_req_o);
  // R7: any-event source lets the software update raise the request
  a_r7_loud_ug: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ug && !src_cnt_only) |=> upd_req_o);
endmodule

// File: tb/upd_timebase_test.sv
`timescale 1ns/1ps
module upd_timebase_test;
  localparam int DATA_W = 16;
  localparam int PSC_W  = 8;
  localparam int CNT_W  = 8;
  localparam int REP_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CNT_W-1:0] cnt_o;
  logic upd_evt_o, upd_req_o;

  upd_timebase #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W), .REP_W(REP_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .upd_evt_o(upd_evt_o), .upd_req_o(upd_req_o));

  always #2 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  bit cmp_on = 0;
  string phase = "R1";

  // behavioural reference state
  int m_en, m_pc, m_cnt, m_rep, m_psc_a, m_arr_a, m_psc_p, m_arr_p, m_rep_p;
  int m_evt, m_req;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pc = 0; m_cnt = 0; m_rep = 0; m_psc_a = 0; m_arr_a = 255;
      m_psc_p = 0; m_arr_p = 255; m_rep_p = 0; m_evt = 0; m_req = 0;
    end else begin
      bit ug;
      ug = wr_en && wr_addr == 2'd0 && wr_data[2];
      m_evt = 0; m_req = 0;
      if (ug) begin
        m_cnt = 0; m_pc = 0; m_psc_a = m_psc_p; m_arr_a = m_arr_p; m_rep = m_rep_p;
        m_evt = 1; m_req = wr_data[1] ? 0 : 1;
      end else if (m_en != 0) begin
        if (m_pc == m_psc_a) begin
          m_pc = 0;
          if (m_cnt == m_arr_a) begin
            m_cnt = 0;
            if (m_rep == 0) begin
              m_psc_a = m_psc_p; m_arr_a = m_arr_p; m_rep = m_rep_p;
              m_evt = 1; m_req = 1;
            end else m_rep = m_rep - 1;
          end else m_cnt = m_cnt + 1;
        end else m_pc = m_pc + 1;
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_en = int'(wr_data[0]);
          2'd1: m_psc_p = int'(wr_data) & 255;
          2'd2: m_arr_p = int'(wr_data) & 255;
          default: m_rep_p = int'(wr_data) & 15;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(int'(cnt_o) == m_cnt, phase, "model cnt_o", int'(cnt_o), m_cnt);
      chk(int'(upd_evt_o) == m_evt, phase, "model upd_evt_o", int'(upd_evt_o), m_evt);
      chk(int'(upd_req_o) == m_req, phase, "model upd_req_o", int'(upd_req_o), m_req);
      chk(!(upd_req_o && !upd_evt_o), "R11", "req without evt", int'(upd_req_o), 0);
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_req(output int n, output int mx, output int nev);
    n = 0; mx = 0; nev = 0;
    do begin
      @(negedge clk);
      n++;
      if (int'(cnt_o) > mx) mx = int'(cnt_o);
      if (upd_evt_o && !upd_req_o) nev++;
    end while (!upd_req_o && n < 2000);
    chk(n < 2000, phase, "request pulse seen", n, 0);
  endtask

  task automatic summary();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    int n, mx, nev, v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cnt_o == '0, "R1", "cnt_o in reset", int'(cnt_o), 0);
    chk(!upd_evt_o && !upd_req_o, "R1", "pulses in reset", int'(upd_evt_o), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (4) @(negedge clk);
    chk(cnt_o == '0, "R1", "cnt_o idle after reset", int'(cnt_o), 0);

    // program prescaler 2, limit 4, no repetition; silent software update
    phase = "R6";
    wr(1, 2); wr(2, 4); wr(3, 0);
    wr(0, 6);
    chk(upd_evt_o == 1'b1, "R5", "evt after ug", int'(upd_evt_o), 1);
    chk(upd_req_o == 1'b0, "R6", "req after silent ug", int'(upd_req_o), 0);
    chk(cnt_o == '0, "R5", "cnt after ug", int'(cnt_o), 0);

    // enable, counter-only source: wraps still request
    phase = "R2";
    wr(0, 3);
    wait_req(n, mx, nev);
    chk(upd_evt_o == 1'b1, "R8", "evt with wrap request", int'(upd_evt_o), 1);
    wait_req(n, mx, nev);
    chk(mx == 4, "R2", "largest count", mx, 4);
    chk(n == 15, "R3", "request spacing", n, 15);
    chk(nev == 0, "R8", "events without request", nev, 0);

    // new period limit is deferred until the next update
    phase = "R4";
    repeat (5) @(negedge clk);
    wr(2, 7);
    wait_req(n, mx, nev);
    chk(mx == 4, "R4", "old limit in running period", mx, 4);
    wait_req(n, mx, nev);
    chk(mx == 7, "R4", "new limit after update", mx, 7);
    chk(n == 24, "R4", "new period length", n, 24);

    // loud software update while running
    phase = "R7";
    repeat (4) @(negedge clk);
    wr(0, 5);
    chk(upd_evt_o == 1'b1, "R7", "evt after loud ug", int'(upd_evt_o), 1);
    chk(upd_req_o == 1'b1, "R7", "req after loud ug", int'(upd_req_o), 1);
    phase = "R5";
    chk(cnt_o == '0, "R5", "cnt after ug 0", int'(cnt_o), 0);
    @(negedge clk); chk(cnt_o == '0, "R5", "cnt after ug 1", int'(cnt_o), 0);
    @(negedge clk); chk(cnt_o == '0, "R5", "cnt after ug 2", int'(cnt_o), 0);
    @(negedge clk); chk(cnt_o == 8'd1, "R5", "prescaler restarted", int'(cnt_o), 1);

    // repetition of 2: one update per three wraps
    phase = "R9";
    wr(3, 2);
    wr(0, 7);
    chk(upd_req_o == 1'b0, "R9", "silent ug loads repetition", int'(upd_req_o), 0);
    wait_req(n, mx, nev);
    chk(n == 72, "R9", "first repeated spacing", n, 72);
    chk(nev == 0, "R9", "events between requests", nev, 0);
    wait_req(n, mx, nev);
    chk(n == 72, "R9", "second repeated spacing", n, 72);

    // disable holds, re-enable resumes
    phase = "R10";
    repeat (10) @(negedge clk);
    wr(0, 2);
    v = int'(cnt_o);
    nev = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (upd_evt_o) nev++;
    end
    chk(int'(cnt_o) == v, "R10", "held count", int'(cnt_o), v);
    chk(nev == 0, "R10", "events while disabled", nev, 0);
    wr(0, 3);
    repeat (3) @(negedge clk);
    chk(int'(cnt_o) == (v + 1) % 8, "R10", "resumed count", int'(cnt_o), (v + 1) % 8);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule